// File: doc/BRIEF.md
# Serial Converter Peer Model

This block is a synthesizable model of the digital side of a low-rate 24-bit converter that talks to a host over one serial clock input and one combined ready/data output. It is meant to sit in a host verification environment as the device the host firmware or host RTL talks to. The model does no signal arithmetic. At a fixed interval it takes a fresh result word, either from a free-running internal counter or from an input port. The port value is clipped to the 24-bit two's-complement range.

The host sees a single output pin. A low level means a fresh word is waiting. Rising serial clock edges then turn that pin into the data line, most significant bit first. Every control action is coded in the serial clock alone. Extra clock pulses after the data request a calibration, and a clock held high puts the model to sleep. Shortly before each new word, the model refuses to be read and holds the pin high. A mode output exposes the internal phase to the bench.

Top module: `adc_emu_dev`

## Requirements
- R1: While reset is held and after it is released, mode_o is 2'b10 (calibrating), dout_o is 1 and overrun_o is 0. The first word becomes ready (dout_o low, mode_o 2'b00) CAL_CYCLES clocks after reset release.
- R2: In conversion, successive ready indications are exactly CONV_CYCLES clocks apart when nobody reads.
- R3: During the last UPD_CYCLES clocks of each conversion period, mode_o is 2'b01 and dout_o is 1. Serial clock edges in that window shift nothing out.
- R4: After ready, each rising serial clock edge puts the next bit of the word on dout_o, most significant bit (bit 23) first, for 24 edges.
- R5: After the 24th bit, dout_o keeps that bit's value until the update window begins.
- R6: A 25th rising edge drives dout_o to 1.
- R7: The falling edge of a 26th clock sets mode_o to 2'b10 with dout_o at 1. The next word is ready CAL_CYCLES clocks later and carries the selected source value.
- R8: A serial clock held high for SLEEP_CYCLES during conversion sets mode_o to 2'b11 with dout_o at 1. Sleep lasts while the clock stays high. When the clock goes low, conversion restarts (mode_o 2'b00) and the next word is ready CONV_CYCLES clocks later.
- R9: If 25 rising edges were given before the clock is held high into sleep, waking sets mode_o to 2'b10 and the word follows CAL_CYCLES clocks later.
- R10: With src_sel_i=1, sample_i (signed, 26 bits) is loaded as is when in range. Values above 8388607 give 24'h7FFFFF, and values below -8388608 give 24'h800000.
- R11: With src_sel_i=0, each new word is one more than the previous word, modulo 2^24.
- R12: overrun_o goes to 1 when a word is replaced before any bit of it was read. It returns to 0 on the first read edge of a later word.
- R13: mode_o is 2'b00 while converting outside the update window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Model clock; all timing counts its cycles |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the host (asynchronous, synchronized inside) |
| src_sel_i | input | 1 | Word source: 0 internal counter, 1 sample_i |
| sample_i | input | IN_W | Signed value used as the word when src_sel_i is 1 |
| dout_o | output | 1 | Combined ready (low) and serial data pin |
| mode_o | output | 2 | 00 converting, 01 updating, 10 calibrating, 11 sleeping |
| overrun_o | output | 1 | A word was lost without being read |

## Verification
The bench reads a word whose last bit is 0 and checks that the pin stays low afterwards. A model that returned the pin high after 24 bits would break host polling. It pulses the clock inside the update window and then reads a full, unshifted word; a model that shifted there would deliver a word missing its top bits. It separates the 25th edge from the falling edge of the 26th and checks sleep with and without a preceding 25th edge. Confusing these would give a calibration in place of a sleep, or a wake with no calibration. Port values just past both ends of the range must come out clipped, not wrapped.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;
  typedef enum logic [1:0] {
    MODE_CONV  = 2'b00,
    MODE_UPD   = 2'b01,
    MODE_CAL   = 2'b10,
    MODE_SLEEP = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'b00,
    ST_CAL   = 2'b01,
    ST_SLEEP = 2'b10
  } st_e;
endpackage

// File: rtl/adc_emu_sync.sv
module adc_emu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sclk_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], sclk_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/adc_emu_src.sv
module adc_emu_src #(
  parameter int DATA_W = 24,
  parameter int IN_W   = 26
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     adv_i,
  input  logic                     sel_i,
  input  logic signed [IN_W-1:0]   sample_i,
  output logic [DATA_W-1:0]        word_o
);
  localparam int XW = IN_W - DATA_W + 1;
  localparam logic signed [IN_W-1:0] POS_LIM = {{XW{1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [IN_W-1:0] NEG_LIM = {{XW{1'b1}}, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] clip_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    if (sample_i > POS_LIM)      clip_w = {1'b0, {(DATA_W-1){1'b1}}};
    else if (sample_i < NEG_LIM) clip_w = {1'b1, {(DATA_W-1){1'b0}}};
    else                         clip_w = sample_i[DATA_W-1:0];
  end

  assign word_o = sel_i ? clip_w : cnt_q;
endmodule

// File: rtl/adc_emu_shift.sv
module adc_emu_shift #(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              rise_i,
  input  logic              set_i,
  input  logic              force_hi_i,
  output logic              dout_o,
  output logic [CNT_W-1:0]  bcnt_o,
  output logic              ovr_o
);
  localparam logic [CNT_W-1:0] N_BITS = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] N_XTRA = CNT_W'(DATA_W + 2);
  // all-ones: nothing to read, extra clocks do nothing
  localparam logic [CNT_W-1:0] EMPTY  = '1;

  logic [DATA_W-1:0] sreg_q;
  logic              pin_q;
  logic [CNT_W-1:0]  bcnt_q;
  logic              ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      pin_q  <= 1'b1;
      bcnt_q <= EMPTY;
      ovr_q  <= 1'b0;
    end else if (set_i) begin
      pin_q  <= 1'b1;
      bcnt_q <= EMPTY;
    end else if (load_i) begin
      sreg_q <= word_i;
      pin_q  <= 1'b0;
      bcnt_q <= '0;
      if (bcnt_q == '0) ovr_q <= 1'b1;
    end else if (rise_i) begin
      if (bcnt_q < N_BITS) begin
        pin_q  <= sreg_q[DATA_W-1];
        sreg_q <= {sreg_q[DATA_W-2:0], 1'b0};
        bcnt_q <= bcnt_q + 1'b1;
        if (bcnt_q == '0) ovr_q <= 1'b0;
      end else if (bcnt_q < N_XTRA) begin
        pin_q  <= 1'b1;
        bcnt_q <= bcnt_q + 1'b1;
      end
    end
  end

  assign dout_o = pin_q | force_hi_i;
  assign bcnt_o = bcnt_q;
  assign ovr_o  = ovr_q;
endmodule

// File: rtl/adc_emu_dev.sv
module adc_emu_dev
  import adc_emu_pkg::*;
#(
  parameter int DATA_W       = 24,
  parameter int IN_W         = 26,
  parameter int CONV_CYCLES  = 163840,
  parameter int UPD_CYCLES   = 374,
  parameter int CAL_CYCLES   = 516096,
  parameter int SLEEP_CYCLES = 163430,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sclk_i,
  input  logic                   src_sel_i,
  input  logic signed [IN_W-1:0] sample_i,
  output logic                   dout_o,
  output logic [1:0]             mode_o,
  output logic                   overrun_o
);
  localparam int CNT_W   = $clog2(DATA_W + 3);
  localparam int TMR_MAX = (CONV_CYCLES > CAL_CYCLES) ? CONV_CYCLES : CAL_CYCLES;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int SLP_W   = $clog2(SLEEP_CYCLES + 1);

  localparam logic [TMR_W-1:0] CONV_LAST = TMR_W'(CONV_CYCLES - 1);
  localparam logic [TMR_W-1:0] UPD_START = TMR_W'(CONV_CYCLES - UPD_CYCLES);
  localparam logic [TMR_W-1:0] CAL_LAST  = TMR_W'(CAL_CYCLES - 1);
  localparam logic [SLP_W-1:0] SLP_LAST  = SLP_W'(SLEEP_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_CAL   = CNT_W'(DATA_W + 2);
  localparam logic [CNT_W-1:0] CNT_25    = CNT_W'(DATA_W + 1);

  st_e               st_q;
  logic [TMR_W-1:0]  tmr_q;
  logic [SLP_W-1:0]  slp_q;
  logic              cal_wake_q;

  logic              lvl, rise, fall;
  logic              upd, load, rise_ok, cal_req, slp_hit, set_hi, force_hi;
  logic [DATA_W-1:0] word;
  logic [CNT_W-1:0]  bcnt;

  adc_emu_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i),
    .lvl_o (lvl),   .rise_o(rise),   .fall_o(fall)
  );

  adc_emu_src #(.DATA_W(DATA_W), .IN_W(IN_W)) u_src (
    .clk_i (clk_i), .rst_ni(rst_ni), .adv_i(load), .sel_i(src_sel_i),
    .sample_i(sample_i), .word_o(word)
  );

  adc_emu_shift #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(load), .word_i(word),
    .rise_i(rise_ok), .set_i(set_hi), .force_hi_i(force_hi),
    .dout_o(dout_o), .bcnt_o(bcnt), .ovr_o(overrun_o)
  );

  assign upd      = (st_q == ST_RUN) && (tmr_q >= UPD_START);
  assign load     = ((st_q == ST_RUN) && (tmr_q == CONV_LAST)) ||
                    ((st_q == ST_CAL) && (tmr_q == CAL_LAST));
  assign rise_ok  = rise && (st_q == ST_RUN) && !upd;
  assign cal_req  = fall && (st_q == ST_RUN) && !upd && (bcnt == CNT_CAL);
  assign slp_hit  = (st_q == ST_RUN) && lvl && (slp_q == SLP_LAST);
  assign set_hi   = cal_req || slp_hit;
  assign force_hi = upd || (st_q != ST_RUN);

  always_comb begin
    unique case (st_q)
      ST_CAL:   mode_o = MODE_CAL;
      ST_SLEEP: mode_o = MODE_SLEEP;
      default:  mode_o = upd ? MODE_UPD : MODE_CONV;
    endcase
  end

  // sleep timer: continuous high level while converting
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   slp_q <= '0;
    else if (st_q == ST_RUN && lvl) slp_q <= slp_hit ? '0 : slp_q + 1'b1;
    else                           slp_q <= '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_CAL;
      tmr_q      <= '0;
      cal_wake_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (slp_hit) begin
            st_q       <= ST_SLEEP;
            tmr_q      <= '0;
            cal_wake_q <= (bcnt == CNT_25);
          end else if (cal_req) begin
            st_q  <= ST_CAL;
            tmr_q <= '0;
          end else if (tmr_q == CONV_LAST) begin
            tmr_q <= '0;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_CAL: begin
          if (tmr_q == CAL_LAST) begin
            st_q  <= ST_RUN;
            tmr_q <= '0;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        default: begin
          if (!lvl) begin
            st_q  <= cal_wake_q ? ST_CAL : ST_RUN;
            tmr_q <= '0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_emu_dev_chk.sv
module adc_emu_dev_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       dout_o,
  input logic [1:0] mode_o,
  input logic       overrun_o
);
  // R3
  upd_pin_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b01) |-> dout_o);

  // R7
  cal_pin_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b10) |-> dout_o);

  // R8
  sleep_pin_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b11) |-> dout_o);

  // R8
  sleep_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b11) |=> (mode_o != 2'b01));

  // R12
  ovr_on_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> (!dout_o && mode_o == 2'b00));

  // R7
  no_cal_in_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b01) |=> (mode_o != 2'b10));
endmodule

bind adc_emu_dev adc_emu_dev_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dout_o(dout_o),
  .mode_o(mode_o), .overrun_o(overrun_o)
);

// File: tb/adc_emu_dev_bench.sv
module adc_emu_dev_bench;
  localparam int CONV  = 2000;
  localparam int UPD   = 100;
  localparam int CAL   = 3000;
  localparam int SLEEP = 500;
  localparam int HALF  = 8;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               sclk;
  logic               sel;
  logic signed [25:0] smp;
  logic               dout;
  logic [1:0]         mode;
  logic               ovr;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  adc_emu_dev #(
    .DATA_W(24), .IN_W(26), .CONV_CYCLES(CONV), .UPD_CYCLES(UPD),
    .CAL_CYCLES(CAL), .SLEEP_CYCLES(SLEEP), .SYNC_STAGES(2)
  ) u_adc_emu_dev (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .src_sel_i(sel),
    .sample_i(smp), .dout_o(dout), .mode_o(mode), .overrun_o(ovr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (dout !== 1'b1 && n < 10000) begin @(negedge clk); n++; end
    while (!(dout === 1'b0 && mode == 2'b00) && n < 10000) begin @(negedge clk); n++; end
    if (n >= 10000) chk(1'b0, "R2 ready timeout", n, 0);
  endtask

  task automatic pulse();
    sclk = 1'b1; repeat (HALF) @(negedge clk);
    sclk = 1'b0; repeat (HALF) @(negedge clk);
  endtask

  task automatic read_word(output logic [23:0] w);
    w = '0;
    for (int i = 0; i < 24; i++) begin
      sclk = 1'b1; repeat (HALF) @(negedge clk);
      w = {w[22:0], dout};
      sclk = 1'b0; repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic t_powerup();
    int n;
    wait_ready(n);
    chk(n >= CAL - 3 && n <= CAL + 3, "R1 first ready delay", n, CAL);
  endtask

  task automatic t_period();
    int n;
    wait_ready(n);
    chk(n == CONV, "R2 period", n, CONV);
    chk(mode == 2'b00, "R13 mode converting", mode, 0);
  endtask

  task automatic t_update();
    int n;
    logic [23:0] w;
    smp = 26'sh05A3C96;
    repeat (CONV - UPD - 5) @(negedge clk);
    chk(mode == 2'b00, "R13 mode before window", mode, 0);
    repeat (10) @(negedge clk);
    chk(mode == 2'b01 && dout == 1'b1, "R3 window mode/pin", {mode, dout}, 3'b011);
    sclk = 1'b1; repeat (HALF) @(negedge clk);
    chk(dout == 1'b1, "R3 pin during window clock", dout, 1);
    sclk = 1'b0; repeat (HALF) @(negedge clk);
    wait_ready(n);
    read_word(w);
    chk(w == 24'h5A3C96, "R3 R4 full word after window", w, 24'h5A3C96);
  endtask

  task automatic t_tail();
    int n;
    logic [23:0] w;
    repeat (200) @(negedge clk);
    chk(dout == 1'b0 && mode == 2'b00, "R5 last bit held", {mode, dout}, 0);
    sclk = 1'b1; repeat (HALF) @(negedge clk);
    chk(dout == 1'b1, "R6 25th clock high", dout, 1);
    sclk = 1'b0; repeat (HALF) @(negedge clk);
    sclk = 1'b1; repeat (HALF) @(negedge clk);
    chk(mode == 2'b00, "R7 no cal before fall", mode, 0);
    sclk = 1'b0; repeat (5) @(negedge clk);
    chk(mode == 2'b10 && dout == 1'b1, "R7 cal mode", {mode, dout}, 3'b101);
    wait_ready(n);
    chk(n + 5 >= CAL && n + 5 <= CAL + 8, "R7 cal duration", n + 5, CAL);
    read_word(w);
    chk(w == 24'h5A3C96, "R7 word after cal", w, 24'h5A3C96);
  endtask

  task automatic t_clip(input logic signed [25:0] v, input logic [23:0] exp);
    int n;
    logic [23:0] w;
    smp = v;
    wait_ready(n);
    wait_ready(n);
    read_word(w);
    chk(w == exp, "R10 clip/pass", w, exp);
  endtask

  task automatic t_overrun();
    int n;
    wait_ready(n);
    wait_ready(n);
    chk(ovr == 1'b1, "R12 overrun set", ovr, 1);
    pulse();
    chk(ovr == 1'b0, "R12 overrun cleared", ovr, 0);
  endtask

  task automatic t_counter();
    int n;
    logic [23:0] a, b;
    sel = 1'b0;
    wait_ready(n);
    wait_ready(n);
    read_word(a);
    wait_ready(n);
    read_word(b);
    chk(b == a + 24'd1, "R11 counter step", b, a + 24'd1);
  endtask

  task automatic t_sleep();
    int n;
    wait_ready(n);
    sclk = 1'b1;
    repeat (SLEEP - 20) @(negedge clk);
    chk(mode == 2'b00, "R8 not yet asleep", mode, 0);
    repeat (30) @(negedge clk);
    chk(mode == 2'b11 && dout == 1'b1, "R8 asleep", {mode, dout}, 3'b111);
    repeat (3000) @(negedge clk);
    chk(mode == 2'b11, "R8 stays asleep", mode, 3);
    sclk = 1'b0; repeat (5) @(negedge clk);
    chk(mode == 2'b00 && dout == 1'b1, "R8 wake converting", {mode, dout}, 3'b001);
    wait_ready(n);
    chk(n + 5 >= CONV && n + 5 <= CONV + 8, "R8 wake to ready", n + 5, CONV);
  endtask

  task automatic t_sleep_cal();
    int n;
    logic [23:0] w;
    sel = 1'b1;
    smp = 26'sh0123456;
    wait_ready(n);
    wait_ready(n);
    read_word(w);
    sclk = 1'b1;
    repeat (SLEEP + 30) @(negedge clk);
    chk(mode == 2'b11, "R9 asleep after 25", mode, 3);
    sclk = 1'b0; repeat (5) @(negedge clk);
    chk(mode == 2'b10, "R9 wake into cal", mode, 2);
    wait_ready(n);
    chk(n + 5 >= CAL && n + 5 <= CAL + 8, "R9 cal after wake", n + 5, CAL);
    read_word(w);
    chk(w == 24'h123456, "R9 word after wake cal", w, 24'h123456);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "R2 watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sclk = 1'b0; sel = 1'b1; smp = '0;
    repeat (5) @(negedge clk);
    chk(mode == 2'b10 && dout == 1'b1 && ovr == 1'b0, "R1 reset state",
        {mode, dout, ovr}, 4'b1010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mode == 2'b10 && dout == 1'b1, "R1 after release", {mode, dout}, 3'b101);
    t_powerup();
    t_period();
    t_update();
    t_tail();
    t_clip(26'sd9000000, 24'h7FFFFF);
    t_clip(-26'sd9000000, 24'h800000);
    t_clip(-26'sd5, 24'hFFFFFB);
    t_overrun();
    t_counter();
    t_sleep();
    t_sleep_cal();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule